// File: doc/BRIEF.md
# Hex-Up / Decimal-Down Seven-Segment Digit Counter

The block keeps one 4-bit digit and steps it on a slow periodic tick. A prescaler followed by a modulus counter produces the tick. While an active-low mode switch is released, the digit counts up through hexadecimal values 0 to F and wraps to 0. While the switch is held, the digit counts down through decimal values and snaps to 9 whenever the result is not below ten.

After every update the new digit is encoded into an active-low seven-segment pattern. The pattern is placed on the segment outputs. One cycle later a single-cycle load strobe is raised, so an external edge-triggered display register can capture the pattern with the data already settled. After reset, the pattern for digit 0 is pushed to the display once before the first tick arrives.

The switch passes through a two-flop synchronizer and is looked at only on the tick cycle. With a 9.8304 MHz clock and the default divide values the digit moves twice per second.

Top module: `hexdec_seg_counter`

## Requirements
- R1: A tick occurs every PRESCALE*MODULUS clock cycles. With the defaults of 256 and 19200 this is 2 Hz at 9.8304 MHz. The tick is one cycle wide, so load strobes caused by ticks are exactly that many cycles apart.
- R2: With sw_ni = 1 (released) at the tick, the digit increments. F is followed by 0.
- R3: With sw_ni = 0 (pressed) at the tick, the digit decrements. Any result of 10 or more is replaced by 9, so 0 goes to 9 and every value from A to F goes to 9.
- R4: The digit changes only on a tick. The switch reaches the update logic through two flops and is sampled only in the tick cycle, so a switch pulse that ends before the tick has no effect.
- R5: seg_o[6] drives segment A, seg_o[5] drives B, and so on down to seg_o[0], which drives G. A segment is lit when its bit is 0. The lit-high patterns for digits 0 to F are 7E,30,6D,79,33,5B,5F,70,7F,73,77,1F,4E,3D,4F,47, and seg_o carries the bitwise inverse.
- R6: Each update changes seg_o one cycle before load_o rises. load_o is high for exactly one cycle, and seg_o does not change in that cycle.
- R7: During reset seg_o is 7F (all segments dark) and load_o is 0. After reset is released, seg_o becomes 01 (digit 0) on the first edge and load_o pulses on the second edge. This happens before any tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_ni | input | 1 | Mode switch, 0 = pressed (decimal down), 1 = released (hex up) |
| seg_o | output | 7 | Active-low segment data, bit 6 = A through bit 0 = G |
| load_o | output | 1 | One-cycle strobe for the external display register |

## Verification
The bench builds the block with PRESCALE = 2 and MODULUS = 4, so a tick arrives every 8 cycles instead of every 4.9 million. This keeps tick spacing exact and short. Within a few thousand cycles the bench can walk the full hexadecimal wrap, the decimal snap from every value from A to F, and a long random mix of both modes. The short period also leaves room for a switch pulse to arrive and vanish between two ticks.

// File: rtl/seg_ctr_pkg.sv
package seg_ctr_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;
  localparam digit_t DEC_MAX = digit_t'(9);
endpackage

// File: rtl/seg_tick_gen.sv
module seg_tick_gen #(
  parameter int unsigned PRESCALE = 256,
  parameter int unsigned MODULUS  = 19200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned MOD_W = (MODULUS > 1) ? $clog2(MODULUS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [MOD_W-1:0] MOD_LAST = MOD_W'(MODULUS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MOD_W-1:0] mod_q;
  logic pre_last;

  assign pre_last = (pre_q == PRE_LAST);
  assign tick_o   = pre_last && (mod_q == MOD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      mod_q <= '0;
    end else begin
      pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (pre_last) mod_q <= (mod_q == MOD_LAST) ? '0 : mod_q + 1'b1;
    end
  end

  p_pre_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST);
  p_mod_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_q <= MOD_LAST);

  generate
    if (PRESCALE * MODULUS > 1) begin : g_pulse_chk
      p_tick_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/seg_digit_step.sv
module seg_digit_step
  import seg_ctr_pkg::*;
(
  input  digit_t digit_i,
  input  logic   up_i,
  output digit_t digit_o
);
  digit_t dec;

  always_comb begin
    dec = digit_i - 1'b1;
    if (up_i) digit_o = digit_i + 1'b1;      // natural wrap F -> 0
    else      digit_o = (dec > DEC_MAX) ? DEC_MAX : dec;
  end
endmodule

// File: rtl/seg_encode.sv
module seg_encode
  import seg_ctr_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   seg_no
);
  seg_t lit;

  // bit 6 = A ... bit 0 = G, active high before inversion
  always_comb begin
    case (digit_i)
      4'h0: lit = 7'h7e;
      4'h1: lit = 7'h30;
      4'h2: lit = 7'h6d;
      4'h3: lit = 7'h79;
      4'h4: lit = 7'h33;
      4'h5: lit = 7'h5b;
      4'h6: lit = 7'h5f;
      4'h7: lit = 7'h70;
      4'h8: lit = 7'h7f;
      4'h9: lit = 7'h73;
      4'ha: lit = 7'h77;
      4'hb: lit = 7'h1f;
      4'hc: lit = 7'h4e;
      4'hd: lit = 7'h3d;
      4'he: lit = 7'h4f;
      default: lit = 7'h47;
    endcase
    seg_no = ~lit;
  end
endmodule

// File: rtl/hexdec_seg_counter.sv
module hexdec_seg_counter
  import seg_ctr_pkg::*;
#(
  parameter int unsigned PRESCALE = 256,
  parameter int unsigned MODULUS  = 19200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_ni,
  output logic [6:0] seg_o,
  output logic       load_o
);
  logic   tick;
  logic   sw_meta_q, sw_q;
  digit_t digit_q, digit_nxt;
  seg_t   seg_enc, seg_q;
  logic   upd_q, pend_q, load_q;

  seg_tick_gen #(.PRESCALE(PRESCALE), .MODULUS(MODULUS)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  seg_digit_step i_step (
    .digit_i(digit_q),
    .up_i   (sw_q),
    .digit_o(digit_nxt)
  );

  seg_encode i_enc (
    .digit_i(digit_q),
    .seg_no (seg_enc)
  );

  // two-flop switch synchronizer, released = 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_meta_q <= 1'b1;
      sw_q      <= 1'b1;
    end else begin
      sw_meta_q <= sw_ni;
      sw_q      <= sw_meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   digit_q <= '0;
    else if (tick) digit_q <= digit_nxt;
  end

  // update -> segment data -> strobe; upd_q resets high for the initial load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= 1'b1;
      pend_q <= 1'b0;
      load_q <= 1'b0;
      seg_q  <= '1;
    end else begin
      upd_q  <= tick;
      pend_q <= upd_q;
      load_q <= pend_q;
      if (upd_q) seg_q <= seg_enc;
    end
  end

  assign seg_o  = seg_q;
  assign load_o = load_q;

  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && sw_q |=> digit_q == digit_t'($past(digit_q) + 1'b1));
  p_down_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !sw_q |=> digit_q <= DEC_MAX);
  p_down_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !sw_q && digit_q != '0 && digit_q <= DEC_MAX
      |=> digit_q == digit_t'($past(digit_q) - 1'b1));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(digit_q));
  p_load_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_seg_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $stable(seg_o));
  p_seg_then_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_o) |-> !load_o ##1 load_o);
endmodule

// File: tb/test_hexdec_seg_counter.sv
`timescale 1ns/1ps
module test_hexdec_seg_counter;
  localparam int PRE = 2;
  localparam int MOD = 4;
  localparam int GAP = PRE * MOD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_n = 1'b1;
  logic [6:0] seg;
  logic       load;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_d;
  logic [6:0] s_prev1, s_prev2;

  always #4 clk = ~clk;

  hexdec_seg_counter #(.PRESCALE(PRE), .MODULUS(MOD)) i_hexdec_seg_counter (
    .clk_i (clk),
    .rst_ni(rst_n),
    .sw_ni (sw_n),
    .seg_o (seg),
    .load_o(load)
  );

  function automatic logic [6:0] lit_pat(input logic [3:0] d);
    logic [6:0] t [16] = '{7'h7e, 7'h30, 7'h6d, 7'h79, 7'h33, 7'h5b, 7'h5f, 7'h70,
                           7'h7f, 7'h73, 7'h77, 7'h1f, 7'h4e, 7'h3d, 7'h4f, 7'h47};
    return t[d];
  endfunction

  function automatic logic [3:0] next_digit(input logic [3:0] d, input logic up);
    if (up) return (d == 4'hf) ? 4'h0 : d + 4'h1;
    if (d == 4'h0 || d > 4'h9) return 4'h9;
    return d - 4'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // waits at negedges until load is seen; records seg history
  task automatic wait_load(output int cyc);
    logic [6:0] cur;
    cyc = 0;
    cur = seg;
    s_prev1 = seg;
    s_prev2 = seg;
    do begin
      s_prev2 = s_prev1;
      s_prev1 = cur;
      @(negedge clk);
      cur = seg;
      cyc++;
      if (cyc > 4 * GAP) begin
        chk(1'b0, "watchdog", cyc, GAP);
        finish_run();
      end
    end while (!load);
  endtask

  task automatic check_load(input int gap, input string tag);
    chk(seg == ~lit_pat(exp_d), {tag, "/R5 value"}, seg, ~lit_pat(exp_d));
    chk(gap == GAP, "R1 tick spacing", gap, GAP);
    chk(s_prev1 == seg && s_prev2 != seg, "R6 data before strobe", s_prev2, seg);
  endtask

  task automatic step(input logic up);
    int gap;
    sw_n = up;
    wait_load(gap);
    exp_d = next_digit(exp_d, up);
    check_load(gap, up ? "R2" : "R3");
  endtask

  initial begin
    int gap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(seg == 7'h7f, "R7 reset seg", seg, 7'h7f);
    chk(load == 1'b0, "R7 reset load", load, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg == 7'h01 && load == 1'b0, "R7 first edge", {load, seg}, 8'h01);
    @(negedge clk);
    chk(seg == 7'h01 && load == 1'b1, "R7 initial load", {load, seg}, 8'h81);
    exp_d = 4'h0;

    // R2: all 16 patterns and the F -> 0 wrap, then back up to F
    for (int i = 0; i < 16; i++) step(1'b1);
    for (int i = 0; i < 15; i++) step(1'b1);
    // R3: F snaps to 9, then down through 0 and back to 9
    step(1'b0);
    for (int i = 0; i < 10; i++) step(1'b0);

    // R4: a short pressed pulse between ticks is ignored
    sw_n = 1'b0;
    @(negedge clk);
    sw_n = 1'b1;
    wait_load(gap);
    exp_d = next_digit(exp_d, 1'b1);
    chk(seg == ~lit_pat(exp_d), "R4 pulse ignored", seg, ~lit_pat(exp_d));
    chk(gap + 1 == GAP, "R4 no extra load", gap + 1, GAP);
    step(1'b0); // A -> 9

    for (int i = 0; i < 120; i++) step(1'($urandom_range(0, 1)));
    finish_run();
  end
endmodule